// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block is a small, set-associative perceptron that predicts the direction of branches that simpler direction predictors get wrong. A table of 16 rows by 2 ways holds 32 entries, each with an address tag, a usefulness counter, a protection counter and 17 signed weights. The 17 weights cover 34 path-history bits: each weight has a select bit that chooses between two history positions. When a weight keeps drifting back to zero, the select bit moves it to the other position.

A lookup is purely combinational. It returns whether the address has an entry, the entry's direction, and whether the entry has earned the right to provide the final prediction. At completion the resolved direction trains the weights, using the history snapshot taken at prediction time. The same event moves the usefulness counter according to how the perceptron compared with the provider in use. An install request allocates an entry, but only after the victim's protection counter has run down to zero.

Top module: `percp_predictor`

## Requirements
- R1: The row is address bits [3:0] and the tag is address bits [15:4]. A lookup hits only when a valid way of that row holds the tag. After reset no address hits.
- R2: Weight i reads history bit i when its select bit is 0 and history bit i+17 when it is 1. Each weight is added when its bit is 1 and subtracted when its bit is 0. The lookup reports taken when the sum is zero or more, and the direction is meaningful only on a hit.
- R3: A completion that hits trains every weight. A weight moves +1 when its selected bit equals the resolved direction (1 for taken) and −1 otherwise, saturating at +31 and −32. The result is visible to lookups from the next cycle.
- R4: When training would move a weight from +1 or −1 to zero, the weight is cleared and its select bit is toggled.
- R5: Usefulness rises by one when the perceptron (its direction from the stored weights and the snapshot history) is right and the provider was wrong. It falls by one when the perceptron is wrong and the provider was right. It rises by one when both are wrong, but only while it is below the threshold.
- R6: The provider flag is high only on a hit whose usefulness is at least PROV_THRESH (default 8).
- R7: An install of an address that misses writes a valid entry with zero weights, select bits 0, usefulness 0 and protection 3. An install of an address that already hits changes nothing.
- R8: The victim is the lowest-numbered invalid way. If all ways are valid, it is the way with the smallest usefulness, with the lower way winning a tie. If the victim is valid with nonzero protection, its protection drops by one and nothing is replaced.
- R9: An install in the same cycle as a completion is ignored. A completion that misses changes no entry.
- R10: Usefulness saturates at 15 and at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkAddr | input | 16 | Lookup address |
| lkHist | input | 34 | Path history for the lookup |
| lkHit | output | 1 | Lookup found an entry |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| lkUseful | output | 1 | Entry may act as provider |
| cmpValid | input | 1 | Completion event present |
| cmpAddr | input | 16 | Address of the resolved branch |
| cmpHist | input | 34 | History snapshot from prediction time |
| cmpTaken | input | 1 | Resolved direction |
| cmpProvCorrect | input | 1 | The provider in use predicted correctly |
| insValid | input | 1 | Install request |
| insAddr | input | 16 | Address to install |

## Verification
The assertions take for granted that reset is held across at least one clock edge, which makes every tag in the table unique from the start. They also assume the completion history is a consistent 34-bit snapshot, because training reads whichever half each select bit points at. The stimulus stays within these limits. Completions and installs are driven at the falling edge and released after the rising edge. Every install, completion and collision targets an address whose current table state is known. Installs are also aimed at rows that are already full, so the protection countdown is exercised rather than only the invalid-way path.

// File: rtl/percp_pkg.sv
package percp_pkg;
  parameter int ADDR_W = 16;
  parameter int N_SETS = 16;
  parameter int N_WAYS = 2;
  parameter int N_WTS  = 17;
  parameter int WT_W   = 6;
  parameter int USE_W  = 4;
  parameter int PROT_W = 2;

  localparam int HIST_W = 2 * N_WTS;
  localparam int IDX_W  = $clog2(N_SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int WAY_W  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
  localparam int SUM_W  = WT_W + $clog2(N_WTS) + 1;

  typedef logic [WT_W-1:0] wt_t;
  localparam wt_t WT_MAX  = wt_t'((1 << (WT_W - 1)) - 1);
  localparam wt_t WT_MIN  = wt_t'(1 << (WT_W - 1));
  localparam wt_t WT_POS1 = wt_t'(1);
  localparam wt_t WT_NEG1 = '1;

  typedef struct packed {
    logic                   valid;
    logic [TAG_W-1:0]       tag;
    logic [PROT_W-1:0]      prot;
    logic [USE_W-1:0]       useCnt;
    logic [N_WTS-1:0]       sel;
    wt_t  [N_WTS-1:0]       wts;
  } entry_t;

  typedef struct packed {
    logic             train;
    logic             useInc;
    logic             useDec;
    logic             install;
    logic             protDec;
    logic [WAY_W-1:0] way;
  } strobe_t;

  function automatic logic [IDX_W-1:0] rowOf(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic selBit(input entry_t e, input logic [HIST_W-1:0] h, input int i);
    return e.sel[i] ? h[i + N_WTS] : h[i];
  endfunction

  // Signed dot product of weights against the selected history bits.
  function automatic logic signed [SUM_W-1:0] dotSum(input entry_t e, input logic [HIST_W-1:0] h);
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] term;
    acc = '0;
    for (int i = 0; i < N_WTS; i++) begin
      term = {{(SUM_W - WT_W){e.wts[i][WT_W-1]}}, e.wts[i]};
      acc  = selBit(e, h, i) ? acc + term : acc - term;
    end
    return acc;
  endfunction

  // Weight training with saturation and zero-crossing remap.
  function automatic entry_t trainWts(input entry_t e, input logic [HIST_W-1:0] h, input logic taken);
    entry_t n;
    logic   up;
    wt_t    old;
    n = e;
    for (int i = 0; i < N_WTS; i++) begin
      up  = (selBit(e, h, i) == taken);
      old = e.wts[i];
      if ((old == WT_POS1 && !up) || (old == WT_NEG1 && up)) begin
        n.wts[i] = '0;
        n.sel[i] = ~e.sel[i];
      end else if (up && old != WT_MAX) begin
        n.wts[i] = old + 1'b1;
      end else if (!up && old != WT_MIN) begin
        n.wts[i] = old - 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/percp_control.sv
module percp_control
  import percp_pkg::*;
#(
  parameter int PROV_THRESH = 8
) (
  input  logic                           cmpValid,
  input  logic                           cmpTaken,
  input  logic                           cmpProvCorrect,
  input  logic                           cmpHit,
  input  logic [WAY_W-1:0]               cmpWay,
  input  logic                           cmpPercTaken,
  input  logic [USE_W-1:0]               cmpUse,
  input  logic                           insValid,
  input  logic                           insHit,
  input  logic [N_WAYS-1:0]              insValidV,
  input  logic [N_WAYS-1:0][USE_W-1:0]   insUseV,
  input  logic [N_WAYS-1:0][PROT_W-1:0]  insProtV,
  output strobe_t                        strobe
);
  logic             percRight;
  logic             replaceReq;
  logic             victimFree;
  logic [WAY_W-1:0] victim;

  // Victim: lowest invalid way, else lowest way of minimum usefulness.
  always_comb begin
    int   v;
    logic haveFree;
    v        = 0;
    haveFree = 1'b0;
    for (int w = N_WAYS - 1; w >= 0; w--) begin
      if (!insValidV[w]) begin
        v        = w;
        haveFree = 1'b1;
      end
    end
    if (!haveFree) begin
      for (int w = N_WAYS - 1; w >= 0; w--) begin
        if (insUseV[w] <= insUseV[v]) v = w;
      end
    end
    victim = WAY_W'(v);
  end

  assign percRight  = (cmpPercTaken == cmpTaken);
  assign replaceReq = insValid && !cmpValid && !insHit;
  assign victimFree = !insValidV[victim] || (insProtV[victim] == '0);

  always_comb begin
    strobe         = '0;
    strobe.train   = cmpValid && cmpHit;
    strobe.useInc  = strobe.train && !cmpProvCorrect &&
                     (percRight || (cmpUse < USE_W'(PROV_THRESH)));
    strobe.useDec  = strobe.train && !percRight && cmpProvCorrect;
    strobe.install = replaceReq && victimFree;
    strobe.protDec = replaceReq && !victimFree;
    strobe.way     = strobe.train ? cmpWay : victim;
  end
endmodule

// File: rtl/percp_datapath.sv
module percp_datapath
  import percp_pkg::*;
#(
  parameter int PROV_THRESH = 8,
  parameter int PROT_INIT   = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              lkAddr,
  input  logic [HIST_W-1:0]              lkHist,
  output logic                           lkHit,
  output logic                           lkTaken,
  output logic                           lkUseful,
  input  logic [ADDR_W-1:0]              cmpAddr,
  input  logic [HIST_W-1:0]              cmpHist,
  input  logic                           cmpTaken,
  output logic                           cmpHit,
  output logic [WAY_W-1:0]               cmpWay,
  output logic                           cmpPercTaken,
  output logic [USE_W-1:0]               cmpUse,
  input  logic [ADDR_W-1:0]              insAddr,
  output logic                           insHit,
  output logic [N_WAYS-1:0]              insValidV,
  output logic [N_WAYS-1:0][USE_W-1:0]   insUseV,
  output logic [N_WAYS-1:0][PROT_W-1:0]  insProtV,
  input  strobe_t                        strobe
);
  entry_t tbl [N_SETS][N_WAYS];

  logic [IDX_W-1:0] lkRow, cmpRow, insRow;
  logic [WAY_W-1:0] lkWay;
  entry_t           lkEntry, cmpEntry, trained, fresh;
  logic             dupTag;

  assign lkRow  = rowOf(lkAddr);
  assign cmpRow = rowOf(cmpAddr);
  assign insRow = rowOf(insAddr);

  // Tag match on the three ports; lowest matching way wins.
  always_comb begin
    lkHit = 1'b0;  lkWay  = '0;
    cmpHit = 1'b0; cmpWay = '0;
    insHit = 1'b0;
    for (int w = N_WAYS - 1; w >= 0; w--) begin
      if (tbl[lkRow][w].valid && tbl[lkRow][w].tag == tagOf(lkAddr)) begin
        lkHit = 1'b1; lkWay = WAY_W'(w);
      end
      if (tbl[cmpRow][w].valid && tbl[cmpRow][w].tag == tagOf(cmpAddr)) begin
        cmpHit = 1'b1; cmpWay = WAY_W'(w);
      end
      if (tbl[insRow][w].valid && tbl[insRow][w].tag == tagOf(insAddr)) insHit = 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < N_WAYS; w++) begin : g_rowInfo
      assign insValidV[w] = tbl[insRow][w].valid;
      assign insUseV[w]   = tbl[insRow][w].useCnt;
      assign insProtV[w]  = tbl[insRow][w].prot;
    end
  endgenerate

  assign lkEntry      = tbl[lkRow][lkWay];
  assign lkTaken      = !dotSum(lkEntry, lkHist)[SUM_W-1];
  assign lkUseful     = lkHit && (lkEntry.useCnt >= USE_W'(PROV_THRESH));
  assign cmpEntry     = tbl[cmpRow][cmpWay];
  assign cmpPercTaken = !dotSum(cmpEntry, cmpHist)[SUM_W-1];
  assign cmpUse       = cmpEntry.useCnt;

  always_comb begin
    trained = trainWts(cmpEntry, cmpHist, cmpTaken);
    if (strobe.useInc && cmpEntry.useCnt != '1)      trained.useCnt = cmpEntry.useCnt + 1'b1;
    else if (strobe.useDec && cmpEntry.useCnt != '0) trained.useCnt = cmpEntry.useCnt - 1'b1;
    fresh       = '0;
    fresh.valid = 1'b1;
    fresh.tag   = tagOf(insAddr);
    fresh.prot  = PROT_W'(PROT_INIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N_SETS; r++)
        for (int w = 0; w < N_WAYS; w++) tbl[r][w] <= '0;
    end else begin
      if (strobe.train)   tbl[cmpRow][strobe.way] <= trained;
      if (strobe.install) tbl[insRow][strobe.way] <= fresh;
      if (strobe.protDec) tbl[insRow][strobe.way].prot <= tbl[insRow][strobe.way].prot - 1'b1;
    end
  end

  always_comb begin
    dupTag = 1'b0;
    for (int a = 0; a < N_WAYS; a++)
      for (int b = a + 1; b < N_WAYS; b++)
        if (tbl[insRow][a].valid && tbl[insRow][b].valid && tbl[insRow][a].tag == tbl[insRow][b].tag)
          dupTag = 1'b1;
  end

  assert_exclusive_writes_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.train && (strobe.install || strobe.protDec)) && !(strobe.install && strobe.protDec));

  assert_install_unprotected_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |-> (!tbl[insRow][strobe.way].valid || tbl[insRow][strobe.way].prot == '0));

  assert_prot_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.protDec |=> tbl[$past(insRow)][$past(strobe.way)].prot ==
                       $past(tbl[insRow][strobe.way].prot) - 1'b1);

  assert_use_ceiling_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.train && strobe.useInc && cmpUse == '1) |=>
      tbl[$past(cmpRow)][$past(strobe.way)].useCnt == '1);

  assert_unique_tags_R7: assert property (@(posedge clk) disable iff (!rstN) !dupTag);
endmodule

// File: rtl/percp_predictor.sv
module percp_predictor
  import percp_pkg::*;
#(
  parameter int PROV_THRESH = 8,
  parameter int PROT_INIT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [HIST_W-1:0] lkHist,
  output logic              lkHit,
  output logic              lkTaken,
  output logic              lkUseful,
  input  logic              cmpValid,
  input  logic [ADDR_W-1:0] cmpAddr,
  input  logic [HIST_W-1:0] cmpHist,
  input  logic              cmpTaken,
  input  logic              cmpProvCorrect,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr
);
  strobe_t                       strobe;
  logic                          cmpHit, cmpPercTaken, insHit;
  logic [WAY_W-1:0]              cmpWay;
  logic [USE_W-1:0]              cmpUse;
  logic [N_WAYS-1:0]             insValidV;
  logic [N_WAYS-1:0][USE_W-1:0]  insUseV;
  logic [N_WAYS-1:0][PROT_W-1:0] insProtV;

  percp_control #(.PROV_THRESH(PROV_THRESH)) u_control (
    .cmpValid(cmpValid), .cmpTaken(cmpTaken), .cmpProvCorrect(cmpProvCorrect),
    .cmpHit(cmpHit), .cmpWay(cmpWay), .cmpPercTaken(cmpPercTaken), .cmpUse(cmpUse),
    .insValid(insValid), .insHit(insHit), .insValidV(insValidV),
    .insUseV(insUseV), .insProtV(insProtV), .strobe(strobe)
  );

  percp_datapath #(.PROV_THRESH(PROV_THRESH), .PROT_INIT(PROT_INIT)) u_datapath (
    .clk(clk), .rstN(rstN),
    .lkAddr(lkAddr), .lkHist(lkHist), .lkHit(lkHit), .lkTaken(lkTaken), .lkUseful(lkUseful),
    .cmpAddr(cmpAddr), .cmpHist(cmpHist), .cmpTaken(cmpTaken),
    .cmpHit(cmpHit), .cmpWay(cmpWay), .cmpPercTaken(cmpPercTaken), .cmpUse(cmpUse),
    .insAddr(insAddr), .insHit(insHit), .insValidV(insValidV),
    .insUseV(insUseV), .insProtV(insProtV), .strobe(strobe)
  );
endmodule

// File: tb/percp_predictor_bench.sv
module percp_predictor_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lkAddr = '0, cmpAddr = '0, insAddr = '0;
  logic [33:0] lkHist = '0, cmpHist = '0;
  logic        lkHit, lkTaken, lkUseful;
  logic        cmpValid = 1'b0, cmpTaken = 1'b0, cmpProvCorrect = 1'b0, insValid = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;

  percp_predictor u_percp_predictor (
    .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkHist(lkHist),
    .lkHit(lkHit), .lkTaken(lkTaken), .lkUseful(lkUseful),
    .cmpValid(cmpValid), .cmpAddr(cmpAddr), .cmpHist(cmpHist), .cmpTaken(cmpTaken),
    .cmpProvCorrect(cmpProvCorrect), .insValid(insValid), .insAddr(insAddr)
  );

  always #5 clk = ~clk;

  // Reference model built from the requirements.
  bit        mValid [16][2];
  bit [11:0] mTag   [16][2];
  int        mProt  [16][2];
  int        mUse   [16][2];
  bit        mSel   [16][2][17];
  int        mW     [16][2][17];

  function automatic logic [15:0] mk(int row, int tag);
    return {tag[11:0], row[3:0]};
  endfunction

  function automatic int mFind(logic [15:0] a);
    for (int w = 0; w < 2; w++)
      if (mValid[a[3:0]][w] && mTag[a[3:0]][w] == a[15:4]) return w;
    return -1;
  endfunction

  function automatic int mSum(int r, int w, logic [33:0] h);
    int s = 0;
    for (int i = 0; i < 17; i++) begin
      if (mSel[r][w][i] ? h[i+17] : h[i]) s += mW[r][w][i];
      else s -= mW[r][w][i];
    end
    return s;
  endfunction

  function automatic bit mPred(logic [15:0] a, logic [33:0] h);
    int w = mFind(a);
    return (w < 0) ? 1'b1 : (mSum(a[3:0], w, h) >= 0);
  endfunction

  function automatic void mTrain(logic [15:0] a, logic [33:0] h, bit tk, bit prov);
    int r = a[3:0];
    int w = mFind(a);
    bit right, b, up;
    if (w < 0) return;
    right = ((mSum(r, w, h) >= 0) == tk);
    for (int i = 0; i < 17; i++) begin
      b  = mSel[r][w][i] ? h[i+17] : h[i];
      up = (b == tk);
      if ((mW[r][w][i] == 1 && !up) || (mW[r][w][i] == -1 && up)) begin
        mW[r][w][i] = 0; mSel[r][w][i] = !mSel[r][w][i];
      end else if (up) mW[r][w][i] = (mW[r][w][i] < 31) ? mW[r][w][i] + 1 : 31;
      else             mW[r][w][i] = (mW[r][w][i] > -32) ? mW[r][w][i] - 1 : -32;
    end
    if (right && !prov)                     mUse[r][w] = (mUse[r][w] < 15) ? mUse[r][w] + 1 : 15;
    else if (!right && prov)                mUse[r][w] = (mUse[r][w] > 0) ? mUse[r][w] - 1 : 0;
    else if (!right && !prov && mUse[r][w] < 8) mUse[r][w] = mUse[r][w] + 1;
  endfunction

  function automatic void mInstall(logic [15:0] a);
    int r = a[3:0];
    int v = -1;
    if (mFind(a) >= 0) return;
    for (int w = 1; w >= 0; w--) if (!mValid[r][w]) v = w;
    if (v < 0) v = (mUse[r][1] < mUse[r][0]) ? 1 : 0;
    if (!mValid[r][v] || mProt[r][v] == 0) begin
      mValid[r][v] = 1; mTag[r][v] = a[15:4]; mProt[r][v] = 3; mUse[r][v] = 0;
      for (int i = 0; i < 17; i++) begin mW[r][v][i] = 0; mSel[r][v][i] = 0; end
    end else mProt[r][v] = mProt[r][v] - 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic look(logic [15:0] a, logic [33:0] h, string req);
    int w = mFind(a);
    bit eu;
    lkAddr = a; lkHist = h;
    #1;
    check(lkHit == (w >= 0), req, lkHit, w >= 0, "hit");
    if (w >= 0) begin
      eu = (mUse[a[3:0]][w] >= 8);
      check(lkTaken == mPred(a, h), req, lkTaken, mPred(a, h), "taken");
      check(lkUseful == eu, req, lkUseful, eu, "useful");
    end
  endtask

  task automatic doInstall(logic [15:0] a);
    @(negedge clk); insValid = 1; insAddr = a;
    @(posedge clk); #1 insValid = 0;
    mInstall(a);
  endtask

  task automatic doComplete(logic [15:0] a, logic [33:0] h, bit tk, bit prov);
    @(negedge clk); cmpValid = 1; cmpAddr = a; cmpHist = h; cmpTaken = tk; cmpProvCorrect = prov;
    @(posedge clk); #1 cmpValid = 0;
    mTrain(a, h, tk, prov);
  endtask

  // Train so that the perceptron is right or wrong as asked.
  task automatic doGraded(logic [15:0] a, logic [33:0] h, bit percRight, bit prov);
    bit p = mPred(a, h);
    doComplete(a, h, percRight ? p : !p, prov);
  endtask

  localparam logic [33:0] H1 = {17'h1A5A5, 17'h05A5A};
  localparam logic [33:0] H2 = {17'h0F0F3, 17'h1C3C1};
  localparam logic [33:0] H3 = 34'h3_FFFF_FFFF;

  task automatic testReset();
    look(mk(0, 1), H1, "R1");
    look(mk(15, 12'hABC), H2, "R1");
  endtask

  task automatic testInstallLookup();
    doInstall(mk(2, 12'h100));
    look(mk(2, 12'h100), H1, "R7");
    look(mk(2, 12'h101), H1, "R1");
    look(mk(3, 12'h100), H1, "R1");
  endtask

  task automatic testTrainPatterns();
    logic [15:0] a = mk(2, 12'h100);
    doComplete(a, H1, 1, 1);
    look(a, H1, "R3"); look(a, ~H1, "R2"); look(a, H2, "R2");
    doComplete(a, H2, 0, 1);
    look(a, H2, "R3"); look(a, H1, "R2"); look(a, H3, "R2");
    for (int k = 0; k < 40; k++) doComplete(a, H3, 0, 0);
    look(a, H3, "R3"); look(a, H1, "R2");
    for (int k = 0; k < 40; k++) begin
      doComplete(a, H3, 1, 0);
      look(a, H3, "R3");
    end
  endtask

  task automatic testRemap();
    logic [15:0] a = mk(4, 12'h042);
    doInstall(a);
    doComplete(a, H1, 1, 1);
    doComplete(a, H1, 0, 1);
    look(a, H1, "R4");
    doComplete(a, {17'h15555, 17'h0AAAA}, 1, 1);
    look(a, {17'h15555, 17'h00000}, "R4");
    look(a, {17'h0AAAA, 17'h15555}, "R4");
    look(a, H2, "R4");
  endtask

  task automatic testUsefulness();
    logic [15:0] a = mk(7, 12'h777);
    doInstall(a);
    for (int k = 0; k < 18; k++) begin
      doGraded(a, H2, 1, 0);
      look(a, H2, "R6");
    end
    look(a, H1, "R10");
    for (int k = 0; k < 8; k++) begin
      doGraded(a, H2, 0, 1);
      look(a, H2, "R5");
    end
    doGraded(a, H2, 0, 0);
    look(a, H2, "R5");
    doGraded(a, H2, 0, 0);
    look(a, H2, "R5");
    doGraded(a, H2, 1, 1);
    look(a, H2, "R5");
    for (int k = 0; k < 12; k++) doGraded(a, H1, 0, 1);
    look(a, H1, "R10");
  endtask

  task automatic testProtection();
    logic [15:0] b = mk(5, 12'h011), c = mk(5, 12'h022), d = mk(5, 12'h033);
    doInstall(b); doInstall(c);
    for (int k = 0; k < 4; k++) begin
      doInstall(d);
      look(b, H1, "R8"); look(c, H1, "R8"); look(d, H1, "R8");
    end
  endtask

  task automatic testUseVictim();
    logic [15:0] e = mk(6, 12'h0E0), f = mk(6, 12'h0F0), g = mk(6, 12'h0A0);
    doInstall(e); doInstall(f);
    doGraded(e, H1, 1, 0);
    doGraded(e, H1, 1, 0);
    for (int k = 0; k < 4; k++) begin
      doInstall(g);
      look(e, H1, "R8"); look(f, H1, "R8"); look(g, H1, "R8");
    end
  endtask

  task automatic testCollision();
    logic [15:0] a = mk(7, 12'h777), n = mk(9, 12'h999), m = mk(5, 12'h0FE);
    @(negedge clk);
    cmpValid = 1; cmpAddr = a; cmpHist = H3; cmpTaken = 1; cmpProvCorrect = 0;
    insValid = 1; insAddr = n;
    @(posedge clk); #1 cmpValid = 0; insValid = 0;
    mTrain(a, H3, 1, 0);
    look(n, H1, "R9"); look(a, H3, "R9");
    doComplete(m, H1, 0, 1);
    look(mk(5, 12'h033), H1, "R9"); look(mk(5, 12'h022), H1, "R9");
    doInstall(a);
    look(a, H3, "R7"); look(a, H2, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    testReset();
    testInstallLookup();
    testTrainPatterns();
    testRemap();
    testUsefulness();
    testProtection();
    testUseVictim();
    testCollision();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule